// File: doc/BRIEF.md
# Block-Programmable Video Raster Timer

This block produces the raster timing for a video output whose geometry is set entirely by programmable counts. A frame is a run of blocks. Every block holds the same number of scan lines, and every line holds the same number of byte slots. The block advances one byte slot per clock. Each slot it reports the current block, line and slot numbers, together with a vertical retrace pulse, a horizontal sync pulse, a screen-area enable and a CPU interrupt pulse.

For every slot it also gives the pixel fetch address and the attribute fetch address. The pixel address can optionally be given the legacy line-interleaved bit order. A flash stage takes the attribute byte read from memory and applies one of two flash styles, using a frame-based flash phase.

The geometry is held in 7-bit registers. These are sampled only at the first slot of each block, so a mode change always lands on a block boundary. Memory access and pixel shifting happen elsewhere.

Top module: `blkvid_timing`

## Requirements
- R1: While `rst` is high, every output reads zero. The first slot after `rst` falls is block 0, line 0, slot 0.
- R2: The slot number counts 0 to `cfg_line_slots`-1, then returns to 0 and the line number advances. The line number counts 0 to `cfg_blk_lines`-1, then returns to 0 and the block number advances. The block number counts 0 to `cfg_frame_blks`-1, then returns to 0. A count register holding 0 behaves as if it held 1.
- R3: `vid_vsync` is high for exactly the slot at block 0, line 0, slot 0. `vid_hsync` is high for slot 0 of every line.
- R4: `vid_active` is high exactly when `cfg_scr_first_blk` <= block < `cfg_scr_end_blk` and also `cfg_scr_first_slot` <= slot < `cfg_scr_end_slot`.
- R5: `cpu_irq` is high for one slot, at line 0, slot 0 of the block whose number equals `cfg_irq_blk`. A value of 0 therefore pulses at frame start.
- R6: The linear pixel address equals `cfg_pix_base` in the first slot of a frame. It goes up by one after each slot with `vid_active` high and holds across border slots.
- R7: The attribute address equals `cfg_attr_base` in the first slot of a frame. It goes up by one after each active slot. Every line of a block starts from the attribute address that the block's first line started from. The next block continues from where the previous block ended.
- R8: When the interleave bit is set for the block, `pix_addr` is the linear address with bits [7:5] and bits [10:8] exchanged. `attr_addr` is never reordered.
- R9: `flash_phase` is 0 during the first frame after reset. It changes only at frame start and toggles every 2^`FLASH_LOG2` frames (16 by default).
- R10: `attr_in` has these fields: [2:0] ink, [5:3] paper, [6] passed through, [7] flash enable. `attr_out` in a slot is derived from the `attr_in` present at the clock edge that opened that slot. When the flash enable is set and `flash_phase` is 1, two styles apply. With `cfg_legacy_flash` set, ink and paper are exchanged. With it clear, the ink field takes the paper value and paper stays. In all other cases the byte passes unchanged.
- R11: All `cfg_*` inputs except the two base addresses are sampled at line 0, slot 0 of each block. A change in the middle of a block has no effect on counting, screen area, interleave or flash style until the next block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_blks | input | 7 | Blocks per frame |
| cfg_scr_first_blk | input | 7 | First block of the screen area |
| cfg_scr_end_blk | input | 7 | First block of the lower border |
| cfg_irq_blk | input | 7 | Block that raises the interrupt |
| cfg_blk_lines | input | 7 | Scan lines per block |
| cfg_line_slots | input | 7 | Byte slots per line |
| cfg_scr_first_slot | input | 7 | First screen slot in a line |
| cfg_scr_end_slot | input | 7 | First right-border slot in a line |
| cfg_interleave | input | 1 | Legacy pixel line interleave |
| cfg_legacy_flash | input | 1 | Exchange ink and paper when flashing |
| cfg_pix_base | input | ADDR_W | Pixel base address |
| cfg_attr_base | input | ADDR_W | Attribute base address |
| attr_in | input | 2*INK_W+2 | Attribute byte read for this slot |
| vid_vsync | output | 1 | Vertical retrace pulse |
| vid_hsync | output | 1 | Horizontal sync pulse |
| vid_active | output | 1 | Slot is inside the screen area |
| cpu_irq | output | 1 | Interrupt pulse |
| pos_blk | output | 7 | Current block |
| pos_line | output | 7 | Current line within block |
| pos_slot | output | 7 | Current byte slot within line |
| pix_addr | output | ADDR_W | Pixel fetch address |
| attr_addr | output | ADDR_W | Attribute fetch address |
| attr_out | output | 2*INK_W+2 | Flash-adjusted attribute |
| flash_phase | output | 1 | Current flash phase |

## Verification
The bench keeps the default 14-bit addresses and builds the block with `FLASH_LOG2` = 2. The flash phase then flips every four frames, so several complete flash cycles fit into a run of a few thousand clocks. Frames are kept to a few hundred slots. This allows whole frames to be swept slot by slot under several geometries: a bordered screen, a full-screen area with interleave on a base that crosses the swapped bits, zero-valued and single-slot counts, and a change of geometry in the middle of a block.

// File: rtl/blkvid_pkg.sv
`timescale 1ns/1ps
package blkvid_pkg;
  // Width of every programmable timing register.
  localparam int unsigned REG_W = 7;

  typedef logic [REG_W-1:0] vreg_t;

  // Geometry and mode bits, sampled once per block.
  typedef struct packed {
    vreg_t frame_blks;
    vreg_t scr_first_blk;
    vreg_t scr_end_blk;
    vreg_t irq_blk;
    vreg_t blk_lines;
    vreg_t line_slots;
    vreg_t scr_first_slot;
    vreg_t scr_end_slot;
    logic  interleave;
    logic  legacy_flash;
  } tcfg_t;

  // True when cnt is the last value of a 0..lim-1 count (lim of 0 acts as 1).
  function automatic logic at_limit(input vreg_t cnt, input vreg_t lim);
    return ({1'b0, cnt} + {{REG_W{1'b0}}, 1'b1}) >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/blkvid_seq.sv
`timescale 1ns/1ps
module blkvid_seq
  import blkvid_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  tcfg_t cfg,
  output logic  run,
  output tcfg_t eff,
  output logic  nx_frame,
  output logic  nx_blk,
  output logic  nx_line,
  output logic  nx_scr,
  output vreg_t blk_q,
  output vreg_t line_q,
  output vreg_t slot_q,
  output logic  vsync_q,
  output logic  hsync_q,
  output logic  scr_q,
  output logic  irq_q
);
  logic  run_q;
  tcfg_t shadow_q;
  vreg_t nb, nl, ns;

  // Position of the slot that the next clock edge opens.
  always_comb begin
    nb = blk_q;
    nl = line_q;
    ns = slot_q;
    if (!run_q) begin
      nb = '0;
      nl = '0;
      ns = '0;
    end else if (at_limit(slot_q, shadow_q.line_slots)) begin
      ns = '0;
      if (at_limit(line_q, shadow_q.blk_lines)) begin
        nl = '0;
        nb = at_limit(blk_q, shadow_q.frame_blks) ? '0 : blk_q + vreg_t'(1);
      end else begin
        nl = line_q + vreg_t'(1);
      end
    end else begin
      ns = slot_q + vreg_t'(1);
    end
  end

  assign nx_line  = (ns == '0);
  assign nx_blk   = nx_line && (nl == '0);
  assign nx_frame = nx_blk && (nb == '0);
  // A block's first slot already obeys the freshly sampled settings.
  assign eff      = nx_blk ? cfg : shadow_q;
  assign nx_scr   = (nb >= eff.scr_first_blk) && (nb < eff.scr_end_blk) &&
                    (ns >= eff.scr_first_slot) && (ns < eff.scr_end_slot);
  assign run      = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      shadow_q <= '0;
      blk_q    <= '0;
      line_q   <= '0;
      slot_q   <= '0;
      vsync_q  <= 1'b0;
      hsync_q  <= 1'b0;
      scr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      shadow_q <= eff;
      blk_q    <= nb;
      line_q   <= nl;
      slot_q   <= ns;
      vsync_q  <= nx_frame;
      hsync_q  <= nx_line;
      scr_q    <= nx_scr;
      irq_q    <= nx_blk && (nb == eff.irq_blk);
    end
  end
endmodule

// File: rtl/blkvid_addr.sv
`timescale 1ns/1ps
module blkvid_addr #(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned SWAP_LO = 5,
  parameter int unsigned SWAP_N  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nx_frame,
  input  logic              nx_blk,
  input  logic              nx_line,
  input  logic              nx_scr,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] pix_base,
  input  logic [ADDR_W-1:0] attr_base,
  output logic [ADDR_W-1:0] pix_addr_q,
  output logic [ADDR_W-1:0] attr_addr_q
);
  localparam int unsigned HI_LO  = SWAP_LO + SWAP_N;
  localparam int unsigned HI_END = SWAP_LO + 2 * SWAP_N;

  logic [ADDR_W-1:0] pix_ptr_q, attr_ptr_q, attr_blk_q;
  logic [ADDR_W-1:0] pcur, pswap, acur;

  // Linear address used by the slot being opened.
  assign pcur = nx_frame ? pix_base : pix_ptr_q;

  always_comb begin
    if (nx_frame)     acur = attr_base;
    else if (nx_blk)  acur = attr_ptr_q;
    else if (nx_line) acur = attr_blk_q;
    else              acur = attr_ptr_q;
  end

  // Bit reorder for the legacy interleave: two equal fields trade places.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_map
    if (i >= SWAP_LO && i < HI_LO) begin : g_low
      assign pswap[i] = pcur[i + SWAP_N];
    end else if (i >= HI_LO && i < HI_END) begin : g_high
      assign pswap[i] = pcur[i - SWAP_N];
    end else begin : g_keep
      assign pswap[i] = pcur[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_ptr_q   <= '0;
      attr_ptr_q  <= '0;
      attr_blk_q  <= '0;
      pix_addr_q  <= '0;
      attr_addr_q <= '0;
    end else begin
      pix_ptr_q   <= nx_scr ? pcur + ADDR_W'(1) : pcur;
      attr_ptr_q  <= nx_scr ? acur + ADDR_W'(1) : acur;
      if (nx_blk) attr_blk_q <= acur;
      pix_addr_q  <= interleave ? pswap : pcur;
      attr_addr_q <= acur;
    end
  end
endmodule

// File: rtl/blkvid_flash.sv
`timescale 1ns/1ps
module blkvid_flash #(
  parameter int unsigned FLASH_LOG2 = 4,
  parameter int unsigned INK_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 nx_frame,
  input  logic                 legacy,
  input  logic [2*INK_W+1:0]   attr_in,
  output logic                 phase_q,
  output logic [2*INK_W+1:0]   attr_q
);
  localparam int unsigned ATTR_W = 2 * INK_W + 2;
  localparam int unsigned CNT_W  = FLASH_LOG2 + 1;

  logic [CNT_W-1:0] frm_q, frm_n;
  logic             phase_n;
  logic [INK_W-1:0] ink, paper, ink_n, paper_n;

  // The very first frame after reset is frame 0 and is not counted.
  assign frm_n   = (run && nx_frame) ? frm_q + CNT_W'(1) : frm_q;
  assign phase_n = frm_n[CNT_W-1];
  assign ink     = attr_in[INK_W-1:0];
  assign paper   = attr_in[2*INK_W-1:INK_W];

  always_comb begin
    ink_n   = ink;
    paper_n = paper;
    if (attr_in[ATTR_W-1] && phase_n) begin
      ink_n   = paper;
      paper_n = legacy ? ink : paper;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q   <= '0;
      phase_q <= 1'b0;
      attr_q  <= '0;
    end else begin
      frm_q   <= frm_n;
      phase_q <= phase_n;
      attr_q  <= {attr_in[ATTR_W-1:2*INK_W], paper_n, ink_n};
    end
  end
endmodule

// File: rtl/blkvid_timing.sv
`timescale 1ns/1ps
module blkvid_timing
  import blkvid_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned FLASH_LOG2 = 4,
  parameter int unsigned INK_W      = 3,
  parameter int unsigned SWAP_LO    = 5,
  parameter int unsigned SWAP_N     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_W-1:0]     cfg_frame_blks,
  input  logic [REG_W-1:0]     cfg_scr_first_blk,
  input  logic [REG_W-1:0]     cfg_scr_end_blk,
  input  logic [REG_W-1:0]     cfg_irq_blk,
  input  logic [REG_W-1:0]     cfg_blk_lines,
  input  logic [REG_W-1:0]     cfg_line_slots,
  input  logic [REG_W-1:0]     cfg_scr_first_slot,
  input  logic [REG_W-1:0]     cfg_scr_end_slot,
  input  logic                 cfg_interleave,
  input  logic                 cfg_legacy_flash,
  input  logic [ADDR_W-1:0]    cfg_pix_base,
  input  logic [ADDR_W-1:0]    cfg_attr_base,
  input  logic [2*INK_W+1:0]   attr_in,
  output logic                 vid_vsync,
  output logic                 vid_hsync,
  output logic                 vid_active,
  output logic                 cpu_irq,
  output logic [REG_W-1:0]     pos_blk,
  output logic [REG_W-1:0]     pos_line,
  output logic [REG_W-1:0]     pos_slot,
  output logic [ADDR_W-1:0]    pix_addr,
  output logic [ADDR_W-1:0]    attr_addr,
  output logic [2*INK_W+1:0]   attr_out,
  output logic                 flash_phase
);
  tcfg_t cfg, eff;
  logic  run, nx_frame, nx_blk, nx_line, nx_scr;

  always_comb begin
    cfg.frame_blks     = cfg_frame_blks;
    cfg.scr_first_blk  = cfg_scr_first_blk;
    cfg.scr_end_blk    = cfg_scr_end_blk;
    cfg.irq_blk        = cfg_irq_blk;
    cfg.blk_lines      = cfg_blk_lines;
    cfg.line_slots     = cfg_line_slots;
    cfg.scr_first_slot = cfg_scr_first_slot;
    cfg.scr_end_slot   = cfg_scr_end_slot;
    cfg.interleave     = cfg_interleave;
    cfg.legacy_flash   = cfg_legacy_flash;
  end

  blkvid_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .run      (run),
    .eff      (eff),
    .nx_frame (nx_frame),
    .nx_blk   (nx_blk),
    .nx_line  (nx_line),
    .nx_scr   (nx_scr),
    .blk_q    (pos_blk),
    .line_q   (pos_line),
    .slot_q   (pos_slot),
    .vsync_q  (vid_vsync),
    .hsync_q  (vid_hsync),
    .scr_q    (vid_active),
    .irq_q    (cpu_irq)
  );

  blkvid_addr #(
    .ADDR_W  (ADDR_W),
    .SWAP_LO (SWAP_LO),
    .SWAP_N  (SWAP_N)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .nx_frame    (nx_frame),
    .nx_blk      (nx_blk),
    .nx_line     (nx_line),
    .nx_scr      (nx_scr),
    .interleave  (eff.interleave),
    .pix_base    (cfg_pix_base),
    .attr_base   (cfg_attr_base),
    .pix_addr_q  (pix_addr),
    .attr_addr_q (attr_addr)
  );

  blkvid_flash #(
    .FLASH_LOG2 (FLASH_LOG2),
    .INK_W      (INK_W)
  ) u_flash (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .nx_frame (nx_frame),
    .legacy   (eff.legacy_flash),
    .attr_in  (attr_in),
    .phase_q  (flash_phase),
    .attr_q   (attr_out)
  );
endmodule

// File: rtl/blkvid_timing_chk.sv
`timescale 1ns/1ps
module blkvid_timing_chk #(
  parameter int unsigned REG_W  = 7,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              vid_vsync,
  input logic              vid_hsync,
  input logic              vid_active,
  input logic              cpu_irq,
  input logic [REG_W-1:0]  pos_blk,
  input logic [REG_W-1:0]  pos_line,
  input logic [REG_W-1:0]  pos_slot,
  input logic [ADDR_W-1:0] pix_addr,
  input logic [ADDR_W-1:0] attr_addr,
  input logic              flash_phase
);
  logic blk_head;
  assign blk_head = (pos_line == '0) && (pos_slot == '0);

  assert_vsync_home_R3: assert property (@(posedge clk) disable iff (rst)
    vid_vsync |-> (pos_blk == '0) && blk_head);

  assert_hsync_col0_R3: assert property (@(posedge clk) disable iff (rst)
    vid_hsync |-> (pos_slot == '0));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pos_slot != '0) |-> (pos_slot == $past(pos_slot) + 1'b1));

  assert_irq_head_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> blk_head);

  assert_pix_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!vid_active) && !blk_head) |-> $stable(pix_addr));

  assert_attr_step_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(vid_active) && (pos_slot != '0)) |-> (attr_addr == $past(attr_addr) + 1'b1));

  assert_phase_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !vid_vsync |-> $stable(flash_phase));
endmodule

bind blkvid_timing blkvid_timing_chk #(
  .REG_W  (blkvid_pkg::REG_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .vid_vsync   (vid_vsync),
  .vid_hsync   (vid_hsync),
  .vid_active  (vid_active),
  .cpu_irq     (cpu_irq),
  .pos_blk     (pos_blk),
  .pos_line    (pos_line),
  .pos_slot    (pos_slot),
  .pix_addr    (pix_addr),
  .attr_addr   (attr_addr),
  .flash_phase (flash_phase)
);

// File: tb/blkvid_timing_bench.sv
`timescale 1ns/1ps
module blkvid_timing_bench;
  localparam int AW = 14;
  localparam int FL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] c_bpf, c_ss, c_se, c_irq, c_lpb, c_bpl, c_bs, c_be;
  logic c_il, c_leg;
  logic [AW-1:0] c_pb, c_ab;
  logic [7:0] a_in;
  logic vs, hs, act, irq, ph;
  logic [6:0] blk, lin, slt;
  logic [AW-1:0] pa, aa;
  logic [7:0] a_out;

  always #2.5 clk = ~clk;

  blkvid_timing #(.ADDR_W(AW), .FLASH_LOG2(FL)) u_blkvid_timing (
    .clk(clk), .rst(rst),
    .cfg_frame_blks(c_bpf), .cfg_scr_first_blk(c_ss), .cfg_scr_end_blk(c_se),
    .cfg_irq_blk(c_irq), .cfg_blk_lines(c_lpb), .cfg_line_slots(c_bpl),
    .cfg_scr_first_slot(c_bs), .cfg_scr_end_slot(c_be),
    .cfg_interleave(c_il), .cfg_legacy_flash(c_leg),
    .cfg_pix_base(c_pb), .cfg_attr_base(c_ab), .attr_in(a_in),
    .vid_vsync(vs), .vid_hsync(hs), .vid_active(act), .cpu_irq(irq),
    .pos_blk(blk), .pos_line(lin), .pos_slot(slt),
    .pix_addr(pa), .attr_addr(aa), .attr_out(a_out), .flash_phase(ph));

  int nvec = 0, nfail = 0, k = 0;
  bit done = 0;
  string cnt_tag = "R2";
  // reference model state
  bit mrun, first;
  int mb, ml, my, mfrm, mpix, mattr, mablk;
  int s_bpf, s_ss, s_se, s_irq, s_lpb, s_bpl, s_bs, s_be, s_il, s_leg;

  task automatic chk(input string tag, input int act_v, input int exp_v);
    nvec++;
    if (act_v != exp_v) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d (blk %0d line %0d slot %0d)",
               tag, act_v, exp_v, mb, ml, my);
    end
  endtask

  function automatic int swp(input int p);
    return (p & ~32'h7E0) | (((p >> 8) & 7) << 5) | (((p >> 5) & 7) << 8);
  endfunction

  function automatic int flash_ref(input int a, input int phase, input int leg);
    int ink = a & 7, pap = (a >> 3) & 7;
    if (((a >> 7) & 1) == 1 && phase == 1) begin
      int t = ink;
      ink = pap;
      pap = leg ? t : pap;
    end
    return (a & 8'hC0) | (pap << 3) | ink;
  endfunction

  task automatic step_and_check();
    bit bst, fst, scr;
    int pcur, acur;
    @(negedge clk);
    if (!mrun) begin
      mb = 0; ml = 0; my = 0; mrun = 1; first = 1;
    end else begin
      first = 0;
      if (my + 1 >= s_bpl) begin
        my = 0;
        if (ml + 1 >= s_lpb) begin
          ml = 0;
          mb = (mb + 1 >= s_bpf) ? 0 : mb + 1;
        end else ml++;
      end else my++;
    end
    bst = (ml == 0) && (my == 0);
    fst = bst && (mb == 0);
    if (bst) begin   // R11: settings sampled only at block start
      s_bpf = c_bpf; s_ss = c_ss; s_se = c_se; s_irq = c_irq; s_lpb = c_lpb;
      s_bpl = c_bpl; s_bs = c_bs; s_be = c_be; s_il = c_il; s_leg = c_leg;
    end
    if (fst && !first) mfrm++;
    scr = (mb >= s_ss) && (mb < s_se) && (my >= s_bs) && (my < s_be);
    pcur = fst ? int'(c_pb) : mpix;
    mpix = (pcur + int'(scr)) & ((1 << AW) - 1);
    acur = fst ? int'(c_ab) : (bst ? mattr : ((my == 0) ? mablk : mattr));
    if (bst) mablk = acur;
    mattr = (acur + int'(scr)) & ((1 << AW) - 1);

    chk(cnt_tag, {blk, lin, slt}, (mb << 14) | (ml << 7) | my);
    chk("R3 vsync", vs, int'(fst));
    chk("R3 hsync", hs, int'(my == 0));
    chk("R4 active", act, int'(scr));
    chk("R5 irq", irq, int'(bst && mb == s_irq));
    chk(s_il ? "R8 interleaved pix" : "R6 pix", pa, s_il ? swp(pcur) : pcur);
    chk("R7 attr addr", aa, acur);
    chk("R9 phase", ph, (mfrm >> FL) & 1);
    chk("R10 attr", a_out, flash_ref(a_in, (mfrm >> FL) & 1, s_leg));
    k++;
    a_in = 8'((k * 53 + 29) ^ (k >> 3));
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step_and_check();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mrun = 0; mfrm = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        int'({vs, hs, act, irq, ph}) + int'(blk) + int'(lin) + int'(slt) +
        int'(pa) + int'(aa) + int'(a_out), 0);
    rst = 1'b0;
    step_and_check();
    chk("R1 first slot", int'(vs) + int'(blk) + int'(lin) + int'(slt), 1);
  endtask

  task automatic set_cfg(input int bpf, ss, se, iq, lpb, bpl, bs, be, il, leg,
                         input int pb, ab);
    c_bpf = 7'(bpf); c_ss = 7'(ss); c_se = 7'(se); c_irq = 7'(iq);
    c_lpb = 7'(lpb); c_bpl = 7'(bpl); c_bs = 7'(bs); c_be = 7'(be);
    c_il = il[0]; c_leg = leg[0]; c_pb = AW'(pb); c_ab = AW'(ab);
  endtask

  initial begin
    a_in = 8'h00;
    // bordered screen, interrupt at frame start, legacy flash
    set_cfg(6, 1, 4, 0, 3, 10, 2, 7, 0, 1, 'h0100, 'h1800);
    do_reset();
    run_cycles(1800);
    // full screen, late interrupt, interleave, soft flash
    set_cfg(5, 0, 5, 3, 2, 7, 0, 7, 1, 0, 'h07E0, 'h0300);
    do_reset();
    run_cycles(900);
    // zero line count behaves as one line per block
    set_cfg(2, 0, 2, 1, 0, 3, 1, 3, 0, 1, 'h0010, 'h0020);
    do_reset();
    run_cycles(60);
    // single-slot frame: every slot is a frame start
    set_cfg(1, 0, 1, 0, 1, 1, 0, 1, 0, 1, 'h0040, 'h0050);
    do_reset();
    run_cycles(40);
    // R11: geometry change in the middle of a block
    set_cfg(6, 1, 4, 2, 3, 10, 2, 7, 0, 1, 'h0100, 'h1800);
    do_reset();
    cnt_tag = "R11";
    run_cycles(25);
    set_cfg(4, 0, 3, 1, 2, 5, 1, 4, 1, 0, 'h0200, 'h0400);
    run_cycles(700);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule